// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller moves a system-on-chip from its running state into one of four sleep depths and back again. It drives the on-chip power-domain enables, a clock-gate enable, the core supply switch for the PLLs, the main crystal oscillator enable, the external memory self-refresh request and the external regulator power-enable pin. Each depth keeps less powered than the one before it. Standby keeps the oscillator running. Depth 1 also stops the oscillator. Depth 0 also cuts the PLL core supply and leaves only the wake domain and the context RAM powered. Clock-only mode turns everything off, including memory retention and the regulator pin.

Software writes a mode code while the chip is running. The controller then takes the entry steps one at a time. A wake event from an always-on peripheral brings the chip back by undoing the steps in reverse order, and it raises a one-cycle interrupt to the power-management processor. A wake event that arrives partway through entry unwinds only the steps already taken. Entering depth 0 sets a sticky warm-resume flag that boot code can read. From clock-only mode, only a rising edge on the external wake pin restores the regulator, and power-up then proceeds as a cold start with the flag cleared.

The state machine has these states. Entry states: ACTIVE, ENT_SR, ENT_CLK, ENT_PLL and ENT_OSC. Resting states: SLEEP and RTC_OFF. Exit states: EXT_DOM, EXT_OSC, SETTLE, EXT_PLL, EXT_CLK and EXT_SR.

The transitions are as follows:
- ACTIVE goes to ENT_SR on a valid request.
- ENT_SR goes to ENT_CLK once self-refresh is acknowledged, or at once if the mode does not use self-refresh.
- ENT_CLK goes to ENT_PLL, and ENT_PLL goes to ENT_OSC.
- ENT_OSC goes to SLEEP, or to RTC_OFF for clock-only mode.
- A wake event in ENT_SR, ENT_CLK, ENT_PLL or ENT_OSC jumps to EXT_SR, EXT_CLK, EXT_PLL or EXT_OSC respectively.
- SLEEP goes to EXT_DOM on a wake event. RTC_OFF goes to EXT_DOM on an external wake rise.
- EXT_DOM goes to EXT_OSC.
- EXT_OSC goes to SETTLE if the oscillator was off, and to EXT_PLL otherwise. SETTLE goes to EXT_PLL when the count expires.
- EXT_PLL goes to EXT_CLK, and EXT_CLK goes to EXT_SR.
- EXT_SR goes to ACTIVE once the acknowledge is low.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset, all four domain enables, `clk_en`, `pll_core_en`, `osc_en` and `pmic_en` are 1. `sr_req`, `wake_irq`, `resume_flag` and `req_err` are 0.
- R2: A request is accepted only in ACTIVE. The codes are 1 = standby, 2 = depth 1, 3 = depth 0 and 4 = clock-only. A request with code 0, 5, 6 or 7 changes no output except `req_err`, which it sets. `req_err` stays set until the next accepted request clears it. A request made while not in ACTIVE changes nothing.
- R3: Entry proceeds in a fixed order, one output group per clock edge: `sr_req`, then `clk_en` (only after `sr_ack` is seen high, or at once when the mode does not use self-refresh), then `pll_core_en`, then `osc_en`, then the domain enables together with `pmic_en`. Domain enables change only while clocks are gated.
- R4: The resting outputs are `dom_en` bits {3 context RAM, 2 wake, 1 core, 0 processor}, followed by PLL, oscillator, self-refresh and regulator, for each mode:

  | Mode | dom_en | PLL | OSC | SR | PMIC |
  |---|---|---|---|---|---|
  | Standby | 1110 | 1 | 1 | 1 | 1 |
  | Depth 1 | 1110 | 1 | 0 | 1 | 1 |
  | Depth 0 | 1100 | 0 | 0 | 1 | 1 |
  | Clock-only | 0000 | 0 | 0 | 0 | 0 |

  `clk_en` is 0 in all four modes.
- R5: Any bit of `wake_evt` in SLEEP gives a `wake_irq` pulse exactly one cycle long. Exit then restores the domains, then the oscillator, then the PLL supply, then the clocks, and finally drops `sr_req`. The block returns to ACTIVE once `sr_ack` is low.
- R6: When exit turns the oscillator back on, `clk_en` rises exactly `osc_settle_cyc`+3 cycles after `osc_en` rises. `pll_core_en` never rises before `osc_en` has been high for more than `osc_settle_cyc` cycles.
- R7: On exit from standby, where the oscillator never stopped, no settle wait occurs. `clk_en` rises 3 cycles after the domain enables return to all ones, whatever the value of `osc_settle_cyc`.
- R8: A wake event during entry stops the entry, pulses `wake_irq` and undoes only the steps already taken, in reverse order.
- R9: `resume_flag` rises in the same cycle as the depth-0 domain cut. It stays set through wake-ups and later sleeps. Only reset or a wake from clock-only mode clears it.
- R10: In clock-only mode, `pmic_en` is 0 and `wake_evt` has no effect. A rising edge on `ext_wake` sets `pmic_en` and clears `resume_flag` in one cycle. The full exit sequence then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake_evt | input | NWAKE | Wake events from always-on peripherals |
| ext_wake | input | 1 | External wake pin, rising edge used in clock-only mode |
| sr_ack | input | 1 | Memory self-refresh acknowledge |
| osc_settle_cyc | input | CNT_W | Oscillator settle count |
| dom_en | output | 4 | Power-domain enables |
| clk_en | output | 1 | Functional clock enable |
| pll_core_en | output | 1 | PLL core supply switch |
| osc_en | output | 1 | Main crystal oscillator enable |
| sr_req | output | 1 | Memory self-refresh request |
| pmic_en | output | 1 | External regulator power-enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| resume_flag | output | 1 | Sticky warm-resume flag |
| req_err | output | 1 | Invalid request status |

## Verification
The hardest case to reach from the ports is a wake event that lands inside the entry sequence. Its effect depends on the exact cycle. To get there, the bench watches for `clk_en` to fall and asserts a wake bit on that same half-cycle, so the event lands while the machine sits in ENT_CLK. The scoreboard then expects the clock enable to return first and the self-refresh request to drop after it. A second hard case is clock-only mode, where ordinary wake events must do nothing. The bench pulses them there and checks that no output moves before it raises the external pin.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    localparam int MODE_W = 3;
    localparam int DOM_W  = 4;

    // domain enable bit positions
    localparam int DOM_CPU   = 0;
    localparam int DOM_CORE  = 1;
    localparam int DOM_WKUP  = 2;
    localparam int DOM_OCRAM = 3;

    localparam logic [MODE_W-1:0] MODE_STBY = MODE_W'(1);
    localparam logic [MODE_W-1:0] MODE_DS1  = MODE_W'(2);
    localparam logic [MODE_W-1:0] MODE_DS0  = MODE_W'(3);
    localparam logic [MODE_W-1:0] MODE_RTC  = MODE_W'(4);

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic             pll;
        logic             osc;
        logic             sr;
        logic             pmic;
    } prof_t;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic             clk;
        logic             pll;
        logic             osc;
        logic             sr;
        logic             pmic;
        logic             resume;
        logic             err;
        logic             irq;
    } out_t;

    typedef enum logic [3:0] {
        S_ACTIVE,
        S_ENT_SR,
        S_ENT_CLK,
        S_ENT_PLL,
        S_ENT_OSC,
        S_SLEEP,
        S_RTC_OFF,
        S_EXT_DOM,
        S_EXT_OSC,
        S_SETTLE,
        S_EXT_PLL,
        S_EXT_CLK,
        S_EXT_SR
    } state_t;

endpackage

// File: rtl/lpm_mode_decode.sv
`timescale 1ns/1ps
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output logic              valid,
    output prof_t             prof
);

    localparam logic [DOM_W-1:0] DOM_ALL  = '1;
    localparam logic [DOM_W-1:0] DOM_LITE = DOM_ALL & ~(DOM_W'(1) << DOM_CPU);
    localparam logic [DOM_W-1:0] DOM_MIN  = (DOM_W'(1) << DOM_WKUP) | (DOM_W'(1) << DOM_OCRAM);

    always_comb begin
        valid     = 1'b1;
        prof.dom  = DOM_ALL;
        prof.pll  = 1'b1;
        prof.osc  = 1'b1;
        prof.sr   = 1'b0;
        prof.pmic = 1'b1;
        unique case (code)
            MODE_STBY: begin
                prof.dom = DOM_LITE;
                prof.sr  = 1'b1;
            end
            MODE_DS1: begin
                prof.dom = DOM_LITE;
                prof.osc = 1'b0;
                prof.sr  = 1'b1;
            end
            MODE_DS0: begin
                prof.dom = DOM_MIN;
                prof.pll = 1'b0;
                prof.osc = 1'b0;
                prof.sr  = 1'b1;
            end
            MODE_RTC: begin
                prof.dom  = '0;
                prof.pll  = 1'b0;
                prof.osc  = 1'b0;
                prof.pmic = 1'b0;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_wake_detect.sv
`timescale 1ns/1ps
module lpm_wake_detect #(
    parameter int NWAKE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic             ext_wake,
    output logic             wake_any,
    output logic             ext_rise
);

    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_wake;
    end

    assign wake_any = |wake_evt;
    assign ext_rise = ext_wake & ~ext_q;

endmodule

// File: rtl/lpm_settle_timer.sv
`timescale 1ns/1ps
module lpm_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/lpm_seq_ctrl.sv
`timescale 1ns/1ps
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int NWAKE = 4,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [MODE_W-1:0]      req_mode,
    input  logic [NWAKE-1:0]       wake_evt,
    input  logic                   ext_wake,
    input  logic                   sr_ack,
    input  logic [CNT_W-1:0]       osc_settle_cyc,
    output logic [DOM_W-1:0]       dom_en,
    output logic                   clk_en,
    output logic                   pll_core_en,
    output logic                   osc_en,
    output logic                   sr_req,
    output logic                   pmic_en,
    output logic                   wake_irq,
    output logic                   resume_flag,
    output logic                   req_err
);

    localparam out_t OUT_RST = '{dom: '1, clk: 1'b1, pll: 1'b1, osc: 1'b1, sr: 1'b0,
                                 pmic: 1'b1, resume: 1'b0, err: 1'b0, irq: 1'b0};
    localparam int AGE_W = CNT_W + 1;

    state_t            st, st_n;
    out_t              o_q, o_n;
    prof_t             prof_q, prof_n, dec_prof;
    logic [MODE_W-1:0] mode_q, mode_n;
    logic              dec_ok, wake_any, ext_rise, tmr_load, tmr_done;

    lpm_mode_decode u_dec (
        .code  (req_mode),
        .valid (dec_ok),
        .prof  (dec_prof)
    );

    lpm_wake_detect #(.NWAKE(NWAKE)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_evt (wake_evt),
        .ext_wake (ext_wake),
        .wake_any (wake_any),
        .ext_rise (ext_rise)
    );

    lpm_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (osc_settle_cyc),
        .done     (tmr_done)
    );

    // next state and next outputs
    always_comb begin
        st_n     = st;
        o_n      = o_q;
        o_n.irq  = 1'b0;
        prof_n   = prof_q;
        mode_n   = mode_q;
        tmr_load = 1'b0;
        unique case (st)
            S_ACTIVE: begin
                if (req_valid) begin
                    if (dec_ok) begin
                        st_n    = S_ENT_SR;
                        o_n.sr  = dec_prof.sr;
                        o_n.err = 1'b0;
                        prof_n  = dec_prof;
                        mode_n  = req_mode;
                    end else begin
                        o_n.err = 1'b1;
                    end
                end
            end
            S_ENT_SR: begin
                if (wake_any) begin
                    st_n    = S_EXT_SR;
                    o_n.irq = 1'b1;
                end else if (!o_q.sr || sr_ack) begin
                    st_n    = S_ENT_CLK;
                    o_n.clk = 1'b0;
                end
            end
            S_ENT_CLK: begin
                if (wake_any) begin
                    st_n    = S_EXT_CLK;
                    o_n.irq = 1'b1;
                end else begin
                    st_n    = S_ENT_PLL;
                    o_n.pll = prof_q.pll;
                end
            end
            S_ENT_PLL: begin
                if (wake_any) begin
                    st_n    = S_EXT_PLL;
                    o_n.irq = 1'b1;
                end else begin
                    st_n    = S_ENT_OSC;
                    o_n.osc = prof_q.osc;
                end
            end
            S_ENT_OSC: begin
                if (wake_any) begin
                    st_n    = S_EXT_OSC;
                    o_n.irq = 1'b1;
                end else begin
                    o_n.dom  = prof_q.dom;
                    o_n.pmic = prof_q.pmic;
                    if (mode_q == MODE_DS0) o_n.resume = 1'b1;
                    st_n = prof_q.pmic ? S_SLEEP : S_RTC_OFF;
                end
            end
            S_SLEEP: begin
                if (wake_any) begin
                    st_n    = S_EXT_DOM;
                    o_n.irq = 1'b1;
                end
            end
            S_RTC_OFF: begin
                if (ext_rise) begin
                    st_n       = S_EXT_DOM;
                    o_n.pmic   = 1'b1;
                    o_n.resume = 1'b0;
                end
            end
            S_EXT_DOM: begin
                st_n    = S_EXT_OSC;
                o_n.dom = '1;
            end
            S_EXT_OSC: begin
                if (o_q.osc) begin
                    st_n = S_EXT_PLL;
                end else begin
                    st_n     = S_SETTLE;
                    o_n.osc  = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            S_SETTLE: begin
                if (tmr_done) st_n = S_EXT_PLL;
            end
            S_EXT_PLL: begin
                st_n    = S_EXT_CLK;
                o_n.pll = 1'b1;
            end
            S_EXT_CLK: begin
                st_n    = S_EXT_SR;
                o_n.clk = 1'b1;
            end
            S_EXT_SR: begin
                o_n.sr = 1'b0;
                if (!sr_ack) st_n = S_ACTIVE;
            end
            default: st_n = S_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_ACTIVE;
            prof_q <= '0;
            mode_q <= '0;
        end else begin
            st     <= st_n;
            prof_q <= prof_n;
            mode_q <= mode_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= OUT_RST;
        else        o_q <= o_n;
    end

    assign dom_en      = o_q.dom;
    assign clk_en      = o_q.clk;
    assign pll_core_en = o_q.pll;
    assign osc_en      = o_q.osc;
    assign sr_req      = o_q.sr;
    assign pmic_en     = o_q.pmic;
    assign wake_irq    = o_q.irq;
    assign resume_flag = o_q.resume;
    assign req_err     = o_q.err;

    // ---------------- assertions ----------------

    // cycles the oscillator has been running; saturated from reset
    logic [AGE_W-1:0] osc_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            osc_age <= '1;
        else if (!osc_en)      osc_age <= '0;
        else if (osc_age != '1) osc_age <= osc_age + 1'b1;
    end

    assert_gate_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> (!sr_req || $past(sr_ack)));

    assert_dom_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_en != $past(dom_en)) |-> (!clk_en && !$past(clk_en)));

    assert_pll_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_core_en) |-> (osc_en && (osc_age > AGE_W'(osc_settle_cyc))));

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> $past(wake_any));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_err) |-> $past(req_valid));

    assert_resume_ds0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_flag) |-> (sr_req && !osc_en && !pll_core_en && pmic_en));

    assert_pmic_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pmic_en |-> (dom_en == '0 && !osc_en && !clk_en && !sr_req && !pll_core_en));

endmodule

// File: tb/sim_lpm_seq_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic [3:0] wake_evt = '0;
    logic       ext_wake = 1'b0;
    logic       sr_ack = 1'b0;
    logic [7:0] osc_settle_cyc = 8'd3;
    logic [3:0] dom_en;
    logic       clk_en, pll_core_en, osc_en, sr_req, pmic_en, wake_irq, resume_flag, req_err;

    always #10 clk = ~clk;   // 50 MHz

    lpm_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake_evt(wake_evt), .ext_wake(ext_wake), .sr_ack(sr_ack),
        .osc_settle_cyc(osc_settle_cyc), .dom_en(dom_en), .clk_en(clk_en),
        .pll_core_en(pll_core_en), .osc_en(osc_en), .sr_req(sr_req), .pmic_en(pmic_en),
        .wake_irq(wake_irq), .resume_flag(resume_flag), .req_err(req_err)
    );

    int    total = 0, bad = 0, cyc = 0, irq_cnt = 0;
    int    t_osc = 0, t_clk = 0, t_dom = 0;
    bit    mon_en = 1'b0, finished = 1'b0;
    string phase = "R1";

    // snapshot {pmic, sr, osc, pll, clk, dom[3:0], resume, err}
    logic [10:0] q[$];
    logic [10:0] prev_s, last_s;
    logic [3:0]  e_dom = 4'hF;
    logic        e_clk = 1, e_pll = 1, e_osc = 1, e_sr = 0, e_pmic = 1, e_res = 0, e_err = 0;

    function automatic logic [10:0] dut_snap();
        return {pmic_en, sr_req, osc_en, pll_core_en, clk_en, dom_en, resume_flag, req_err};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // driver side: push the expected snapshot when it differs from the last one
    task automatic push();
        logic [10:0] s;
        s = {e_pmic, e_sr, e_osc, e_pll, e_clk, e_dom, e_res, e_err};
        if (s != last_s) begin
            q.push_back(s);
            last_s = s;
        end
    endtask

    always @(posedge clk) cyc++;

    // memory model: acknowledge follows the request half a cycle later
    always @(negedge clk) sr_ack <= sr_req;

    // monitor: compare every output change against the queue
    always @(negedge clk) begin
        if (mon_en) begin
            logic [10:0] cur, ex;
            cur = dut_snap();
            if (cur != prev_s) begin
                if (q.size() == 0) begin
                    chk(1'b0, {phase, " unexpected output change"}, int'(cur), int'(prev_s));
                end else begin
                    ex = q.pop_front();
                    chk(cur == ex, {phase, " output order"}, int'(cur), int'(ex));
                end
                if (!prev_s[8] && cur[8]) t_osc = cyc;
                if (!prev_s[6] && cur[6]) t_clk = cyc;
                if (prev_s[5:2] != 4'hF && cur[5:2] == 4'hF) t_dom = cyc;
                prev_s = cur;
            end
            if (wake_irq) irq_cnt++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input logic [2:0] code);
        @(negedge clk);
        req_valid = 1'b1;
        req_mode  = code;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_evt = 4'b0100;
        @(negedge clk);
        wake_evt = 4'b0000;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (q.size() != 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk(1'b0, {phase, " sequence stalled"}, q.size(), 0);
        step(4);
    endtask

    function automatic logic [7:0] prof(input logic [2:0] code);
        // {dom[3:0], pll, osc, sr, pmic}
        case (code)
            3'd1:    return {4'b1110, 1'b1, 1'b1, 1'b1, 1'b1};
            3'd2:    return {4'b1110, 1'b1, 1'b0, 1'b1, 1'b1};
            3'd3:    return {4'b1100, 1'b0, 1'b0, 1'b1, 1'b1};
            default: return {4'b0000, 1'b0, 1'b0, 1'b0, 1'b0};
        endcase
    endfunction

    task automatic exp_enter(input logic [2:0] code);
        logic [7:0] p;
        p = prof(code);
        e_sr = p[1]; e_err = 1'b0; push();
        e_clk = 1'b0; push();
        e_pll = p[3]; push();
        e_osc = p[2]; push();
        e_dom = p[7:4]; e_pmic = p[0];
        if (code == 3'd3) e_res = 1'b1;
        push();
    endtask

    task automatic exp_exit(input bit cold);
        if (cold) begin e_pmic = 1'b1; e_res = 1'b0; push(); end
        e_dom = 4'hF; push();
        e_osc = 1'b1; push();
        e_pll = 1'b1; push();
        e_clk = 1'b1; push();
        e_sr  = 1'b0; push();
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_up();
    end

    initial begin
        int irq0;
        last_s = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0};
        prev_s = last_s;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk(dut_snap() == last_s, "R1 reset outputs", int'(dut_snap()), int'(last_s));
        chk(wake_irq == 1'b0, "R1 wake_irq at reset", wake_irq, 0);
        mon_en = 1'b1;

        // R2 invalid codes set the error flag only
        phase = "R2";
        e_err = 1'b1; push();
        request(3'd0);
        wait_idle();
        request(3'd6);
        wait_idle();
        chk(req_err == 1'b1, "R2 error stays set", req_err, 1);

        // standby, long settle count that must be skipped
        phase = "R3 R4 standby";
        osc_settle_cyc = 8'd9;
        exp_enter(3'd1);
        request(3'd1);
        wait_idle();
        chk(dut_snap() == last_s, "R4 standby outputs", int'(dut_snap()), int'(last_s));
        chk(req_err == 1'b0, "R2 error cleared by accepted request", req_err, 0);
        phase = "R2 request while asleep";
        request(3'd3);
        step(6);
        chk(dut_snap() == last_s && q.size() == 0, "R2 request ignored when asleep",
            int'(dut_snap()), int'(last_s));
        phase = "R5 standby exit";
        irq0 = irq_cnt;
        exp_exit(1'b0);
        pulse_wake();
        wait_idle();
        chk(irq_cnt == irq0 + 1, "R5 one-cycle wake_irq", irq_cnt - irq0, 1);
        chk(t_clk - t_dom == 3, "R7 standby exit without settle", t_clk - t_dom, 3);

        // depth 1
        phase = "R4 depth1";
        osc_settle_cyc = 8'd4;
        exp_enter(3'd2);
        request(3'd2);
        wait_idle();
        chk(dut_snap() == last_s, "R4 depth1 outputs", int'(dut_snap()), int'(last_s));
        phase = "R5 depth1 exit";
        exp_exit(1'b0);
        pulse_wake();
        wait_idle();
        chk(t_clk - t_osc == 7, "R6 settle 4", t_clk - t_osc, 7);

        // depth 0
        phase = "R9 depth0";
        osc_settle_cyc = 8'd0;
        exp_enter(3'd3);
        request(3'd3);
        wait_idle();
        chk(resume_flag == 1'b1, "R9 resume set on depth0", resume_flag, 1);
        chk(dut_snap() == last_s, "R4 depth0 outputs", int'(dut_snap()), int'(last_s));
        phase = "R5 depth0 exit";
        exp_exit(1'b0);
        pulse_wake();
        wait_idle();
        chk(t_clk - t_osc == 3, "R6 settle 0", t_clk - t_osc, 3);
        chk(resume_flag == 1'b1, "R9 resume sticky after wake", resume_flag, 1);

        // abort depth 1 entry right after the clock gate
        phase = "R8 abort";
        e_sr = 1'b1; push();
        e_clk = 1'b0; push();
        e_clk = 1'b1; push();
        e_sr = 1'b0; push();
        irq0 = irq_cnt;
        request(3'd2);
        while (clk_en !== 1'b0) @(negedge clk);
        wake_evt = 4'b0001;
        @(negedge clk);
        wake_evt = 4'b0000;
        wait_idle();
        chk(irq_cnt == irq0 + 1, "R8 abort raises wake_irq", irq_cnt - irq0, 1);
        chk(osc_en == 1'b1 && pll_core_en == 1'b1, "R8 later steps untouched",
            {osc_en, pll_core_en}, 3);

        // clock-only mode
        phase = "R10 clock-only";
        osc_settle_cyc = 8'd2;
        exp_enter(3'd4);
        request(3'd4);
        wait_idle();
        chk(dut_snap() == last_s, "R4 clock-only outputs", int'(dut_snap()), int'(last_s));
        irq0 = irq_cnt;
        pulse_wake();
        step(6);
        chk(pmic_en == 1'b0 && q.size() == 0 && irq_cnt == irq0,
            "R10 wake_evt ignored", pmic_en, 0);
        exp_exit(1'b1);
        @(negedge clk);
        ext_wake = 1'b1;
        wait_idle();
        ext_wake = 1'b0;
        chk(resume_flag == 1'b0, "R9 resume cleared by cold start", resume_flag, 0);
        chk(pmic_en == 1'b1, "R10 regulator back on", pmic_en, 1);
        chk(t_clk - t_osc == 5, "R6 settle 2", t_clk - t_osc, 5);

        // invalid code after cold start
        phase = "R2 code7";
        e_err = 1'b1; push();
        request(3'd7);
        wait_idle();
        chk(req_err == 1'b1, "R2 code 7 rejected", req_err, 1);
        chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
        finish_up();
    end

endmodule